// File: doc/BRIEF.md
# Zero-or-One-Hot Control-Flow Sequencer

This block steps a hardware-compiled function through its basic blocks. Each basic block owns one bit of an activity register, and at most one bit is ever set. The control-flow graph is fixed at elaboration through parameter arrays. For each block these give up to two predecessors, a taken successor and a not-taken successor. A separate parameter names the final block.

On every clock edge the sequencer forms a start term for each block. The first block has no predecessor, so it follows the external go pulse. Every other block follows its predecessors. A predecessor counts when it is active and its memory traffic has drained. When that predecessor forks, its branch condition must also point at this block.

The lowest-indexed block with a true start term becomes the only active block. The final block raises the end flag once its memory traffic is done. When the final block branches back to itself, the end flag also waits for that loop condition to be false. A registered copy of the start vector is provided for datapath enables that must fire one cycle after a block is entered.

Top module: `cf_sequencer`

## Requirements
- R1: A block with no predecessor (block 0 in the default graph) has a start term equal to `go_i`; from an idle state, `go_i` high makes `active_o` equal 4'b0001 after the next edge.
- R2: A predecessor contributes to a block's start term only while its `active_o` bit and its `mem_done_i` bit are both 1; with the predecessor's `mem_done_i` bit low, `active_o` holds.
- R3: When a predecessor has both a taken and a not-taken successor, its contribution to the taken successor requires its `cond_i` bit = 1, and its contribution to the other successor requires it = 0 (default graph: block 0 goes to block 1 on 1 and to block 2 on 0).
- R4: A block with two predecessors starts when either predecessor's contribution is true (default graph: block 2 from blocks 0 and 1, block 3 from blocks 2 and 3).
- R5: With `rst` high at a clock edge, `active_o` and `start_q_o` become zero after that edge, whatever the other inputs are.
- R6: While `end_o` is high, the next edge clears `active_o` and `start_q_o` to zero, even when a start term, including `go_i`, is true.
- R7: Otherwise, when one or more start terms are true, `active_o` is loaded with only the bit of the lowest-indexed block whose start term is true.
- R8: With no start term true and `end_o` low, `active_o` keeps its value.
- R9: `end_o` is combinational. It equals the final block's `active_o` bit ANDed with that block's `mem_done_i` bit, and, when the final block has a successor (a loop back), also ANDed with the inverse of its `cond_i` bit.
- R10: Outside reset and end, `start_q_o` after an edge equals the start-term vector sampled at that edge, bit i for block i.
- R11: `active_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start pulse for the entry block |
| cond_i | input | NBLK | Branch condition of each block, bit i for block i |
| mem_done_i | input | NBLK | Memory dependencies of block i have completed |
| active_o | output | NBLK | Zero-or-one-hot activity vector |
| start_q_o | output | NBLK | Start-term vector, registered |
| end_o | output | 1 | Function complete |

## Verification
The assertions treat `cond_i` and `mem_done_i` as level inputs that are stable around each clock edge. They place no restriction on how these inputs relate to the activity vector, and `go_i` may be raised while a block is already active. The stimulus changes inputs only at falling edges and deliberately includes go during an active block and go together with end. It also includes a final block that holds for lack of memory completion, and a reset applied with go high. Every property therefore has to hold under overlapping start terms as well as the simple single-path walk.

// File: rtl/cf_seq_pkg.sv
package cf_seq_pkg;

  // marker for "no block" in the graph parameter arrays
  localparam int NO_BLK = -1;

  // a block forks when both successor slots are filled
  function automatic bit is_fork(input int taken, input int other);
    return (taken != NO_BLK) && (other != NO_BLK);
  endfunction

endpackage

// File: rtl/cf_edge_term.sv
// One predecessor-to-block contribution: active, memory drained, and
// (for a forking predecessor) the branch pointing at this block.
module cf_edge_term #(
  parameter int DST   = 0,
  parameter int SUCCT = -1,
  parameter int SUCCF = -1
) (
  input  logic act_i,
  input  logic done_i,
  input  logic cond_i,
  output logic term_o
);
  import cf_seq_pkg::*;

  logic ready;
  assign ready = act_i & done_i;

  if (is_fork(SUCCT, SUCCF)) begin : g_fork
    if (SUCCT == DST) begin : g_taken
      assign term_o = ready & cond_i;
    end else begin : g_other
      assign term_o = ready & ~cond_i;
    end
  end else begin : g_straight
    assign term_o = ready;
  end

endmodule

// File: rtl/cf_start_net.sv
// Start-term vector for all blocks, built from the graph parameters.
module cf_start_net #(
  parameter int NBLK               = 4,
  parameter int PRED_A [NBLK]      = '{-1, 0, 0, 2},
  parameter int PRED_B [NBLK]      = '{-1, -1, 1, 3},
  parameter int SUCC_T [NBLK]      = '{1, 2, 3, 3},
  parameter int SUCC_F [NBLK]      = '{2, -1, -1, -1}
) (
  input  logic            go_i,
  input  logic [NBLK-1:0] act_i,
  input  logic [NBLK-1:0] done_i,
  input  logic [NBLK-1:0] cond_i,
  output logic [NBLK-1:0] start_o
);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    if (PRED_A[b] < 0) begin : g_entry
      assign start_o[b] = go_i;
    end else begin : g_body
      logic term_a;
      logic term_b;

      cf_edge_term #(
        .DST  (b),
        .SUCCT(SUCC_T[PRED_A[b]]),
        .SUCCF(SUCC_F[PRED_A[b]])
      ) u_term_a (
        .act_i (act_i[PRED_A[b]]),
        .done_i(done_i[PRED_A[b]]),
        .cond_i(cond_i[PRED_A[b]]),
        .term_o(term_a)
      );

      if (PRED_B[b] >= 0) begin : g_second
        cf_edge_term #(
          .DST  (b),
          .SUCCT(SUCC_T[PRED_B[b]]),
          .SUCCF(SUCC_F[PRED_B[b]])
        ) u_term_b (
          .act_i (act_i[PRED_B[b]]),
          .done_i(done_i[PRED_B[b]]),
          .cond_i(cond_i[PRED_B[b]]),
          .term_o(term_b)
        );
      end else begin : g_single
        assign term_b = 1'b0;
      end

      assign start_o[b] = term_a | term_b;
    end
  end

endmodule

// File: rtl/cf_pick_low.sv
// Isolates the lowest set bit of a request vector.
module cf_pick_low #(
  parameter int W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] grant_o,
  output logic         any_o
);

  always_comb begin
    grant_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = W'(1) << i;
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/cf_sequencer.sv
module cf_sequencer #(
  parameter int NBLK          = 4,
  parameter int PRED_A [NBLK] = '{-1, 0, 0, 2},
  parameter int PRED_B [NBLK] = '{-1, -1, 1, 3},
  parameter int SUCC_T [NBLK] = '{1, 2, 3, 3},
  parameter int SUCC_F [NBLK] = '{2, -1, -1, -1},
  parameter int LAST          = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  input  logic [NBLK-1:0] cond_i,
  input  logic [NBLK-1:0] mem_done_i,
  output logic [NBLK-1:0] active_o,
  output logic [NBLK-1:0] start_q_o,
  output logic            end_o
);

  localparam bit LOOPS = (SUCC_T[LAST] >= 0) || (SUCC_F[LAST] >= 0);

  logic [NBLK-1:0] act_q;
  logic [NBLK-1:0] start_vec;
  logic [NBLK-1:0] start_r;
  logic [NBLK-1:0] pick;
  logic            any_start;
  logic            fin;
  logic            unused_cond;

  assign unused_cond = ^cond_i;

  cf_start_net #(
    .NBLK  (NBLK),
    .PRED_A(PRED_A),
    .PRED_B(PRED_B),
    .SUCC_T(SUCC_T),
    .SUCC_F(SUCC_F)
  ) u_start (
    .go_i   (go_i),
    .act_i  (act_q),
    .done_i (mem_done_i),
    .cond_i (cond_i),
    .start_o(start_vec)
  );

  cf_pick_low #(.W(NBLK)) u_pick (
    .req_i  (start_vec),
    .grant_o(pick),
    .any_o  (any_start)
  );

  if (LOOPS) begin : g_loop_end
    assign fin = act_q[LAST] & mem_done_i[LAST] & ~cond_i[LAST];
  end else begin : g_plain_end
    assign fin = act_q[LAST] & mem_done_i[LAST];
  end

  always_ff @(posedge clk) begin
    if (rst || fin) begin
      act_q   <= '0;
      start_r <= '0;
    end else begin
      start_r <= start_vec;
      if (any_start) act_q <= pick;
    end
  end

  assign active_o  = act_q;
  assign start_q_o = start_r;
  assign end_o     = fin;

endmodule

// File: rtl/cf_sequencer_chk.sv
module cf_sequencer_chk #(
  parameter int NBLK = 4,
  parameter int LAST = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NBLK-1:0] active_o,
  input logic [NBLK-1:0] start_q_o,
  input logic [NBLK-1:0] start_vec,
  input logic            end_o
);

  // R11
  a_r11_zero_or_one_hot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_o));

  // R5
  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (active_o == '0 && start_q_o == '0));

  // R6
  a_r6_end_clears: assert property (@(posedge clk) disable iff (rst)
    end_o |=> (active_o == '0 && start_q_o == '0));

  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!end_o && start_vec == '0) |=> $stable(active_o));

  // R10
  a_r10_start_copy: assert property (@(posedge clk) disable iff (rst)
    !end_o |=> start_q_o == $past(start_vec));

  // R7
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (!end_o && start_vec != '0) |=>
      ($onehot(active_o) && (active_o & $past(start_vec)) == active_o
       && ((active_o - 1'b1) & $past(start_vec)) == '0));

  // R9
  a_r9_end_needs_last: assert property (@(posedge clk) disable iff (rst)
    end_o |-> active_o[LAST]);

endmodule

bind cf_sequencer cf_sequencer_chk #(.NBLK(NBLK), .LAST(LAST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .active_o (active_o),
  .start_q_o(start_q_o),
  .start_vec(start_vec),
  .end_o    (end_o)
);

// File: tb/test_cf_sequencer.sv
module test_cf_sequencer;

  localparam int NBLK = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            go_i = 1'b0;
  logic [NBLK-1:0] cond_i = '0;
  logic [NBLK-1:0] mem_done_i = '0;
  logic [NBLK-1:0] active_o;
  logic [NBLK-1:0] start_q_o;
  logic            end_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  cf_sequencer i_cf_sequencer (
    .clk       (clk),
    .rst       (rst),
    .go_i      (go_i),
    .cond_i    (cond_i),
    .mem_done_i(mem_done_i),
    .active_o  (active_o),
    .start_q_o (start_q_o),
    .end_o     (end_o)
  );

  // row: [21:18] req, [17] go, [16:13] cond, [12:9] done,
  //      [8] end before edge, [7:4] active after, [3:0] start_q after
  localparam int NROW = 15;
  localparam logic [21:0] TBL [NROW] = '{
    {4'd8,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0000}, // R8 idle
    {4'd1,  1'b1, 4'b0000, 4'b1111, 1'b0, 4'b0001, 4'b0001}, // R1 go
    {4'd2,  1'b0, 4'b0001, 4'b0000, 1'b0, 4'b0001, 4'b0000}, // R2 wait mem
    {4'd3,  1'b0, 4'b0001, 4'b1111, 1'b0, 4'b0010, 4'b0010}, // R3 taken
    {4'd4,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b0100, 4'b0100}, // R4 second pred
    {4'd2,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b1000, 4'b1000}, // R2 to last
    {4'd9,  1'b0, 4'b1000, 4'b1111, 1'b0, 4'b1000, 4'b1000}, // R9 loop held
    {4'd9,  1'b0, 4'b0000, 4'b0111, 1'b0, 4'b1000, 4'b0000}, // R9 mem pending
    {4'd6,  1'b0, 4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b0000}, // R6 end
    {4'd1,  1'b1, 4'b0000, 4'b1111, 1'b0, 4'b0001, 4'b0001}, // R1 restart
    {4'd3,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b0100, 4'b0100}, // R3 not taken
    {4'd7,  1'b1, 4'b0000, 4'b1111, 1'b0, 4'b0001, 4'b1001}, // R7 lowest wins
    {4'd3,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b0100, 4'b0100}, // R3 again
    {4'd2,  1'b0, 4'b0000, 4'b1111, 1'b0, 4'b1000, 4'b1000}, // R2
    {4'd6,  1'b1, 4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b0000}  // R6 end beats go
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset active", 8'(active_o), 8'h0);
    check("R5 reset start_q", 8'(start_q_o), 8'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      go_i       = TBL[r][17];
      cond_i     = TBL[r][16:13];
      mem_done_i = TBL[r][12:9];
      #1;
      check($sformatf("R9 end row %0d", r), 8'(end_o), 8'(TBL[r][8]));
      @(posedge clk);
      #1;
      check($sformatf("R%0d active row %0d", TBL[r][21:18], r), 8'(active_o), 8'(TBL[r][7:4]));
      check($sformatf("R10 start_q row %0d", r), 8'(start_q_o), 8'(TBL[r][3:0]));
      check($sformatf("R11 onehot row %0d", r), 8'($countones(active_o) <= 1), 8'h1);
    end

    // R5: reset mid-run with go high
    @(negedge clk);
    go_i = 1'b1; cond_i = '0; mem_done_i = '1;
    @(posedge clk); #1;
    check("R1 active before reset", 8'(active_o), 8'h1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R5 active under reset", 8'(active_o), 8'h0);
    check("R5 start_q under reset", 8'(start_q_o), 8'h0);

    // R8: idle with no start term holds zero
    @(negedge clk);
    rst = 1'b0; go_i = 1'b0; mem_done_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 idle hold", 8'(active_o), 8'h0);

    // R8: active block with memory pending holds for several cycles
    @(negedge clk);
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R8 active hold", 8'(active_o), 8'h1);
    check("R10 start_q zero while held", 8'(start_q_o), 8'h0);

    finish_run();
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

endmodule